// File: doc/BRIEF.md
# Complementary Pair Dead-Time Inserter

This block turns each of four raw pulse-width signals into a high-side/low-side pin pair ready to drive a power half-bridge. In complementary mode the two pins of a pair are never on together. When the raw signal changes, the pin that is switching off goes off at once. The pin that is switching on waits for a programmable dead time. In independent mode a pair passes two separate sources straight through with no delay and no restriction.

Two dead-time settings, A and B, are shared by all four pairs. Each setting has a 6-bit count and its own prescaler. Each pair has two select bits. One picks A or B for the active edge, when the raw signal rises. The other picks A or B for the inactive edge, when the raw signal falls. Rising and falling transitions can therefore get different blanking times. The outputs feed the downstream override, fault and polarity stages.

Top module: `deadTimeInserter`

## Requirements
- R1: While reset is asserted, all eight pin outputs are 0.
- R2: In complementary mode a pair's high and low pins are never both 1, and with no dead time pending the high pin equals the raw bit and the low pin its inverse, one clock after the raw bit is sampled.
- R3: On a rising raw bit in complementary mode, with a nonzero active-edge count, both pins are 0 from the next clock; the high pin turns on D clocks after the low pin turned off, where D = count × tick.
- R4: On a falling raw bit the inactive-edge setting applies in the same way: the high pin goes off at once and the low pin turns on D clocks later.
- R5: Select bit 1 picks setting B and 0 picks setting A. This is done separately for each pair, for the active edge (selActB) and for the inactive edge (selInactB).
- R6: Prescaler code 0, 1, 2, 3 gives a tick of 1, 2, 4 or 8 clocks for the setting it belongs to.
- R7: A selected count of 0 makes the pair an exact complement of the raw bit, with no blank cycle.
- R8: If the raw bit reverses while a dead time is pending, the count restarts from the new edge's setting and both pins stay 0 until that new count completes.
- R9: In independent mode (comp bit 0) the high pin follows the raw bit and the low pin follows indepLow, each one clock later, with no dead time.
- R10: Count and prescaler are captured at the edge; changing the settings during a pending dead time does not change its length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| raw | input | 4 | Raw PWM bit per pair |
| comp | input | 4 | 1 = complementary mode for the pair |
| indepLow | input | 4 | Low-pin source in independent mode |
| selActB | input | 4 | Active (rising) edge uses B when 1 |
| selInactB | input | 4 | Inactive (falling) edge uses B when 1 |
| valA | input | 6 | Setting A count |
| preA | input | 2 | Setting A prescaler code |
| valB | input | 6 | Setting B count |
| preB | input | 2 | Setting B prescaler code |
| pinHigh | output | 4 | High-side pin per pair |
| pinLow | output | 4 | Low-side pin per pair |

## Verification
The hardest condition to reach is a raw reversal that lands in the middle of a pending dead time. In that case the restarted count must be measured from the second edge, not the first. The bench flips a raw bit, waits four clocks inside a ten-clock window, and flips it back. It then checks that both pins stay off for the full new window. Capture at the edge is reached the same way: the bench rewrites the setting two clocks into a long window and checks that the original length still holds.

// File: rtl/deadTimePkg.sv
package deadTimePkg;
  // Strobes from a channel's control to its counter datapath
  typedef struct packed {
    logic load;   // start a new dead-time window
    logic clear;  // abandon any pending window
  } dtStrobeT;
endpackage

// File: rtl/dtPath.sv
module dtPath
  import deadTimePkg::*;
#(
  parameter int DT_W  = 6,
  parameter int PRE_W = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  dtStrobeT         strobe,
  input  logic [DT_W-1:0]  loadVal,
  input  logic [PRE_W-1:0] loadPre,
  output logic             expire
);
  localparam int LIM_W = (1 << PRE_W) - 1;

  logic [DT_W-1:0]  cntQ;
  logic [LIM_W-1:0] preCntQ;
  logic [LIM_W-1:0] preLimQ;
  logic [LIM_W-1:0] limNext;
  logic             tick;

  // Tick period of 2**code clocks: limit is a run of ones
  always_comb limNext = {LIM_W{1'b1}} >> (LIM_W - int'(loadPre));
  always_comb tick    = (preCntQ == preLimQ);
  always_comb expire  = (cntQ == DT_W'(1)) && tick;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cntQ    <= '0;
      preCntQ <= '0;
      preLimQ <= '0;
    end else if (strobe.clear) begin
      cntQ    <= '0;
      preCntQ <= '0;
    end else if (strobe.load) begin
      cntQ    <= loadVal;
      preCntQ <= '0;
      preLimQ <= limNext;
    end else if (cntQ != '0) begin
      if (tick) begin
        preCntQ <= '0;
        cntQ    <= cntQ - DT_W'(1);
      end else begin
        preCntQ <= preCntQ + LIM_W'(1);
      end
    end
  end

  // R10: a load captures the offered count
  p_load_capture_r10: assert property (@(posedge clk) disable iff (!rstN)
    strobe.load && !strobe.clear |=> cntQ == $past(loadVal));

  // R6: the count only moves on a prescaler tick
  p_count_hold_r6: assert property (@(posedge clk) disable iff (!rstN)
    (cntQ != '0) && !strobe.load && !strobe.clear && !tick |=> cntQ == $past(cntQ));

  // R6: the prescaler never runs past its limit
  p_pre_bound_r6: assert property (@(posedge clk) disable iff (!rstN)
    preCntQ <= preLimQ);
endmodule

// File: rtl/dtCtrl.sv
module dtCtrl
  import deadTimePkg::*;
#(
  parameter int DT_W  = 6,
  parameter int PRE_W = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             raw,
  input  logic             comp,
  input  logic             indepLow,
  input  logic             selActB,
  input  logic             selInactB,
  input  logic [DT_W-1:0]  valA,
  input  logic [PRE_W-1:0] preA,
  input  logic [DT_W-1:0]  valB,
  input  logic [PRE_W-1:0] preB,
  input  logic             expire,
  output dtStrobeT         strobe,
  output logic [DT_W-1:0]  loadVal,
  output logic [PRE_W-1:0] loadPre,
  output logic             pinH,
  output logic             pinL
);
  logic lastRawQ;
  logic pendQ;
  logic rawEdge;
  logic useB;
  logic zeroVal;

  always_comb begin
    rawEdge      = raw ^ lastRawQ;
    useB         = raw ? selActB : selInactB;
    loadVal      = useB ? valB : valA;
    loadPre      = useB ? preB : preA;
    zeroVal      = (loadVal == '0);
    strobe.load  = comp && rawEdge && !zeroVal;
    strobe.clear = !comp || (rawEdge && zeroVal);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      lastRawQ <= 1'b0;
      pendQ    <= 1'b0;
      pinH     <= 1'b0;
      pinL     <= 1'b0;
    end else begin
      lastRawQ <= raw;
      if (!comp) begin
        pendQ <= 1'b0;
        pinH  <= raw;
        pinL  <= indepLow;
      end else if (rawEdge) begin
        pendQ <= !zeroVal;
        pinH  <= zeroVal & raw;
        pinL  <= zeroVal & ~raw;
      end else if (pendQ) begin
        if (expire) begin
          pendQ <= 1'b0;
          pinH  <= raw;
          pinL  <= ~raw;
        end
      end else begin
        pinH <= raw;
        pinL <= ~raw;
      end
    end
  end

  // R2: never both on in complementary mode
  p_no_overlap_r2: assert property (@(posedge clk) disable iff (!rstN)
    comp |=> !(pinH && pinL));

  // R3 / R8: a nonzero edge blanks both pins
  p_edge_blank_r3: assert property (@(posedge clk) disable iff (!rstN)
    comp && rawEdge && !zeroVal |=> !pinH && !pinL);

  // R7: zero count gives an immediate complement
  p_zero_comp_r7: assert property (@(posedge clk) disable iff (!rstN)
    comp && rawEdge && zeroVal |=> (pinH == $past(raw)) && (pinL == !$past(raw)));

  // R9: independent pass-through
  p_indep_follow_r9: assert property (@(posedge clk) disable iff (!rstN)
    !comp |=> (pinH == $past(raw)) && (pinL == $past(indepLow)));
endmodule

// File: rtl/deadTimeInserter.sv
module deadTimeInserter
  import deadTimePkg::*;
#(
  parameter int NUM_PAIRS = 4,
  parameter int DT_W      = 6,
  parameter int PRE_W     = 2
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [NUM_PAIRS-1:0] raw,
  input  logic [NUM_PAIRS-1:0] comp,
  input  logic [NUM_PAIRS-1:0] indepLow,
  input  logic [NUM_PAIRS-1:0] selActB,
  input  logic [NUM_PAIRS-1:0] selInactB,
  input  logic [DT_W-1:0]      valA,
  input  logic [PRE_W-1:0]     preA,
  input  logic [DT_W-1:0]      valB,
  input  logic [PRE_W-1:0]     preB,
  output logic [NUM_PAIRS-1:0] pinHigh,
  output logic [NUM_PAIRS-1:0] pinLow
);
  for (genvar g = 0; g < NUM_PAIRS; g++) begin : g_pair
    dtStrobeT         strobe;
    logic [DT_W-1:0]  loadVal;
    logic [PRE_W-1:0] loadPre;
    logic             expire;

    dtCtrl #(.DT_W(DT_W), .PRE_W(PRE_W)) u_ctrl (
      .clk(clk), .rstN(rstN), .raw(raw[g]), .comp(comp[g]),
      .indepLow(indepLow[g]), .selActB(selActB[g]), .selInactB(selInactB[g]),
      .valA(valA), .preA(preA), .valB(valB), .preB(preB),
      .expire(expire), .strobe(strobe), .loadVal(loadVal), .loadPre(loadPre),
      .pinH(pinHigh[g]), .pinL(pinLow[g])
    );

    dtPath #(.DT_W(DT_W), .PRE_W(PRE_W)) u_path (
      .clk(clk), .rstN(rstN), .strobe(strobe),
      .loadVal(loadVal), .loadPre(loadPre), .expire(expire)
    );
  end
endmodule

// File: tb/sim_deadTimeInserter.sv
`timescale 1ns/1ps
module sim_deadTimeInserter;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [3:0] raw = '0, comp = 4'hF, indepLow = '0, selActB = '0, selInactB = '0;
  logic [5:0] valA = '0, valB = '0;
  logic [1:0] preA = '0, preB = '0;
  logic [3:0] pinHigh, pinLow;
  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  deadTimeInserter u0 (
    .clk(clk), .rstN(rstN), .raw(raw), .comp(comp), .indepLow(indepLow),
    .selActB(selActB), .selInactB(selInactB), .valA(valA), .preA(preA),
    .valB(valB), .preB(preB), .pinHigh(pinHigh), .pinLow(pinLow)
  );

  typedef struct packed {
    logic [1:0] ch;
    logic [5:0] va;
    logic [1:0] pa;
    logic [5:0] vb;
    logic [1:0] pb;
    logic       sAct;
    logic       sInact;
    logic       rise;
    logic [9:0] dly;   // expected count x tick
  } vecT;

  // R3 R4 R5 R6 R7 edge vectors
  localparam vecT VECS [0:9] = '{
    '{2'd0, 6'd3,  2'd0, 6'd5,  2'd0, 1'b0, 1'b1, 1'b1, 10'd3},   // R3 active A
    '{2'd0, 6'd3,  2'd0, 6'd5,  2'd0, 1'b0, 1'b1, 1'b0, 10'd5},   // R4 R5 inactive B
    '{2'd0, 6'd2,  2'd1, 6'd9,  2'd0, 1'b0, 1'b0, 1'b1, 10'd4},   // R6 tick 2
    '{2'd0, 6'd2,  2'd2, 6'd9,  2'd0, 1'b0, 1'b0, 1'b1, 10'd8},   // R6 tick 4
    '{2'd0, 6'd3,  2'd3, 6'd9,  2'd0, 1'b1, 1'b0, 1'b0, 10'd24},  // R4 R6 tick 8
    '{2'd1, 6'd7,  2'd0, 6'd4,  2'd1, 1'b1, 1'b0, 1'b1, 10'd8},   // R5 active B
    '{2'd2, 6'd0,  2'd0, 6'd6,  2'd0, 1'b0, 1'b1, 1'b1, 10'd0},   // R7 zero A
    '{2'd3, 6'd6,  2'd0, 6'd0,  2'd0, 1'b0, 1'b1, 1'b0, 10'd0},   // R7 zero B
    '{2'd3, 6'd1,  2'd0, 6'd2,  2'd0, 1'b0, 1'b0, 1'b1, 10'd1},   // R3 minimum
    '{2'd1, 6'd1,  2'd0, 6'd63, 2'd0, 1'b0, 1'b1, 1'b0, 10'd63}   // R4 maximum
  };

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int pairOf(input int ch);
    return {pinHigh[ch], pinLow[ch]};
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check(pinHigh == 4'h0 && pinLow == 4'h0, "R1 reset pins", {pinHigh, pinLow}, 0);
    rstN = 1'b1;
    @(negedge clk);
    check(pinHigh == 4'h0 && pinLow == 4'hF, "R2 idle complement", {pinHigh, pinLow}, 8'h0F);

    foreach (VECS[v]) begin
      automatic int ch = VECS[v].ch;
      automatic int d  = VECS[v].dly;
      valA = VECS[v].va; preA = VECS[v].pa;
      valB = VECS[v].vb; preB = VECS[v].pb;
      selActB[ch] = VECS[v].sAct; selInactB[ch] = VECS[v].sInact;
      raw[ch] = !VECS[v].rise;
      repeat (520) @(negedge clk);
      raw[ch] = VECS[v].rise;
      for (int k = 1; k <= d + 1; k++) begin
        @(negedge clk);
        if (d >= 1 && (k == 1 || k == d))
          check(pairOf(ch) == 0, $sformatf("R3 R4 blank vec %0d k %0d", v, k), pairOf(ch), 0);
        if (k == d + 1)
          check(pairOf(ch) == (VECS[v].rise ? 2 : 1),
                $sformatf("R3 R4 R5 R6 R7 settle vec %0d", v), pairOf(ch), VECS[v].rise ? 2 : 1);
      end
    end

    // R8: reversal inside a pending window restarts the count
    valA = 6'd10; valB = 6'd10; preA = 2'd0; preB = 2'd0;
    selActB[0] = 1'b0; selInactB[0] = 1'b0;
    raw[0] = 1'b0;
    repeat (520) @(negedge clk);
    raw[0] = 1'b1;
    repeat (4) @(negedge clk);
    raw[0] = 1'b0;
    for (int k = 1; k <= 11; k++) begin
      @(negedge clk);
      if (k == 5 || k == 10) check(pairOf(0) == 0, "R8 still blank", pairOf(0), 0);
      if (k == 11) check(pairOf(0) == 1, "R8 settle low", pairOf(0), 1);
    end

    // R10: a setting change during a window leaves its length alone
    valA = 6'd20;
    raw[0] = 1'b1;
    for (int k = 1; k <= 21; k++) begin
      @(negedge clk);
      if (k == 2) valA = 6'd2;
      if (k == 20) check(pairOf(0) == 0, "R10 still blank", pairOf(0), 0);
      if (k == 21) check(pairOf(0) == 2, "R10 settle high", pairOf(0), 2);
    end

    // R9: independent mode passes both sources through
    valA = 6'd20; valB = 6'd20;
    comp[0] = 1'b0; raw[0] = 1'b1; indepLow[0] = 1'b1;
    @(negedge clk);
    check(pairOf(0) == 3, "R9 both on", pairOf(0), 3);
    raw[0] = 1'b0; indepLow[0] = 1'b0;
    @(negedge clk);
    check(pairOf(0) == 0, "R9 both off", pairOf(0), 0);
    raw[0] = 1'b1;
    @(negedge clk);
    check(pairOf(0) == 2, "R9 no delay", pairOf(0), 2);
    comp[0] = 1'b1;
    @(negedge clk);
    check(pairOf(0) == 2, "R2 back to complement", pairOf(0), 2);

    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule